// File: doc/BRIEF.md
# Multi-channel prescaled PWM generator

A bank of independent pulse-width channels sits behind a byte-wide write/read register port. Each channel owns a 256-byte address window, picked by the address bits above bit 7. A channel counts through 2^CNT_W steps (512 by default), and its output is high while the step count is below a programmed duty value.

The step length is built from one of three reference tick-enable inputs. A pre-divider taken from the set {1, 3, 5, 6} is applied first, then a power-of-two stage of 2^exp. Clock select, divider, exponent and duty are written into shadow copies and only become active when software strobes a sync register. The sync either takes effect at once, restarting the count, or waits for the end of the current period when the channel's glitch-free bit is set.

A gate register holds three controls: the output drive, a tristate choice for the idle state, and selection of the PWM source. Software normally writes the duty value once before enabling and once again after enabling, then syncs. Both writes simply land in the shadow copy.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero, except offset 0x05 which reads the channel kind code 0x0B. Every channel then drives `pwm_out` low with `pwm_oe` high.
- R2: A channel is selected by `bus_addr[9:8]` and the register by `bus_addr[7:0]`. Readback is as follows. 0x41 returns bits [2:0] (clock select in [1:0], width flag in bit 2). 0x42 returns exponent [2:0] and divider index [6:5]. 0x43 returns bit 5 (glitch-free). 0x44 and 0x45 return the duty low and high bytes. 0x46 returns bits 7, 5, 2 and 1. 0x47 reads zero. Any other offset reads zero and ignores writes, and writes to 0x05 are ignored.
- R3: Active clock select 0 stops the channel and holds all of its counters at zero. Codes 1, 2 and 3 count on `ref_tick[0]`, `ref_tick[1]` and `ref_tick[2]` respectively.
- R4: One step lasts ratio·2^exp selected ticks, where divider index 0..3 gives ratio 1, 3, 5, 6. The step counter wraps after 512 steps.
- R5: The raw PWM level is high while the step count is below the duty value. Duty 0 gives a level that is always low, and duty ≥ 512 gives a level that is always high.
- R6: Writes to 0x41, 0x42, 0x44 and 0x45 change only the shadow copy. A write to 0x47 with bit 0 clear has no effect.
- R7: With the glitch-free bit clear, a write to 0x47 with bit 0 set loads the shadow copy into the active settings and zeroes all counters on that clock edge.
- R8: With the glitch-free bit set, a sync is held pending and applied on the step at which the count wraps from 511 to 0. If the active clock select is 0, the sync is applied at once.
- R9: Gate register 0x46 works as follows. With bit 7 clear, `pwm_out` is low, and `pwm_oe` is the inverse of bit 5. With bit 7 set, `pwm_oe` is high and `pwm_out` is the raw level only if bit 2 is set; otherwise `pwm_out` is low.
- R10: A duty value rewritten after the enable bit is set is accepted and applied by the following sync.
- R11: Channels are independent: writes and syncs to one channel leave every other channel's output and registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 10 | Channel index [9:8], register offset [7:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ref_tick | input | 3 | Reference tick enables (slow, medium, fast) |
| pwm_out | output | 4 | PWM level per channel |
| pwm_oe | output | 4 | Pad drive enable per channel |

## Verification
The bench builds the bank with its defaults: four channels, a 9-bit step counter, three tick inputs and the full exponent range. This lets all four windows, every clock select code and the 511-to-0 wrap be reached within a few thousand cycles. The three tick inputs are driven at different rates (every cycle, every third and every seventh), so divider and exponent settings give visibly different step lengths. Several channels run at once, which exposes any cross-channel disturbance.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

   localparam logic [7:0] OFS_KIND   = 8'h05;
   localparam logic [7:0] OFS_CLK    = 8'h41;
   localparam logic [7:0] OFS_DIV    = 8'h42;
   localparam logic [7:0] OFS_MODE   = 8'h43;
   localparam logic [7:0] OFS_DUTY_L = 8'h44;
   localparam logic [7:0] OFS_DUTY_H = 8'h45;
   localparam logic [7:0] OFS_GATE   = 8'h46;
   localparam logic [7:0] OFS_SYNC   = 8'h47;

   localparam logic [7:0] KIND_PLAIN = 8'h0B;

   typedef struct packed {
      logic [1:0]  clk_sel;
      logic [1:0]  div_idx;
      logic [2:0]  exp;
      logic [15:0] duty;
   } pwm_cfg_t;

   // last count of the pre-divider for ratios 1, 3, 5, 6
   function automatic logic [2:0] div_last(input logic [1:0] idx);
      case (idx)
         2'd0:    return 3'd0;
         2'd1:    return 3'd2;
         2'd2:    return 3'd4;
         default: return 3'd5;
      endcase
   endfunction

endpackage

// File: rtl/pwmb_chan_regs.sv
module pwmb_chan_regs
   import pwmb_pkg::*;
#(
   parameter logic [7:0] KIND_CODE = KIND_PLAIN
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] ofs,
   input  logic [7:0] wdata,
   input  logic       boundary,
   output logic [7:0] rdata,
   output pwm_cfg_t   act_cfg,
   output logic       restart,
   output logic       gate_en,
   output logic       gate_tri,
   output logic       gate_pwm
);

   pwm_cfg_t shd_cfg;
   logic     wide_q, glitch_q, pend_q, ramp_q;
   logic     sync_req, load;

   assign sync_req = wr_en && (ofs == OFS_SYNC) && wdata[0];
   assign load     = (sync_req && (!glitch_q || (act_cfg.clk_sel == 2'd0)))
                   || (pend_q && boundary);
   assign restart  = load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_cfg  <= '0;
         act_cfg  <= '0;
         wide_q   <= 1'b0;
         glitch_q <= 1'b0;
         pend_q   <= 1'b0;
         gate_en  <= 1'b0;
         gate_tri <= 1'b0;
         gate_pwm <= 1'b0;
         ramp_q   <= 1'b0;
      end else begin
         if (load) act_cfg <= shd_cfg;
         if (load)          pend_q <= 1'b0;
         else if (sync_req) pend_q <= 1'b1;
         if (wr_en) begin
            case (ofs)
               OFS_CLK: begin
                  shd_cfg.clk_sel <= wdata[1:0];
                  wide_q          <= wdata[2];
               end
               OFS_DIV: begin
                  shd_cfg.exp     <= wdata[2:0];
                  shd_cfg.div_idx <= wdata[6:5];
               end
               OFS_MODE:   glitch_q           <= wdata[5];
               OFS_DUTY_L: shd_cfg.duty[7:0]  <= wdata;
               OFS_DUTY_H: shd_cfg.duty[15:8] <= wdata;
               OFS_GATE: begin
                  gate_en  <= wdata[7];
                  gate_tri <= wdata[5];
                  gate_pwm <= wdata[2];
                  ramp_q   <= wdata[1];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (ofs)
         OFS_KIND:   rdata = KIND_CODE;
         OFS_CLK:    rdata = {5'd0, wide_q, shd_cfg.clk_sel};
         OFS_DIV:    rdata = {1'b0, shd_cfg.div_idx, 2'b00, shd_cfg.exp};
         OFS_MODE:   rdata = {2'b00, glitch_q, 5'd0};
         OFS_DUTY_L: rdata = shd_cfg.duty[7:0];
         OFS_DUTY_H: rdata = shd_cfg.duty[15:8];
         OFS_GATE:   rdata = {gate_en, 1'b0, gate_tri, 2'b00, gate_pwm, ramp_q, 1'b0};
         default:    rdata = 8'h00;
      endcase
   end

   // R7: immediate sync copies the shadow into the active set
   p_sync_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_req && !glitch_q) |=> (act_cfg == $past(shd_cfg)));

   // R6: without a sync write or a pending sync the active set is frozen
   p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && (ofs == OFS_SYNC)) && !pend_q) |=> $stable(act_cfg));

   // R8: a glitch-free sync on a running channel is deferred
   p_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_req && glitch_q && (act_cfg.clk_sel != 2'd0) && !(pend_q && boundary))
      |=> pend_q);

endmodule

// File: rtl/pwmb_prescale.sv
module pwmb_prescale
   import pwmb_pkg::*;
#(
   parameter  int MAX_EXP = 7,
   localparam int EXC_W   = (MAX_EXP > 0) ? MAX_EXP : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] div_idx,
   input  logic [2:0] exp,
   output logic       step
);

   logic [2:0] pd_q;
   logic       pd_last, ex_last;

   assign pd_last = (pd_q == div_last(div_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pd_q <= '0;
      else if (restart || !run)  pd_q <= '0;
      else if (tick)             pd_q <= pd_last ? 3'd0 : pd_q + 3'd1;
   end

   generate
      if (MAX_EXP == 0) begin : g_no_exp
         assign ex_last = 1'b1;
      end else begin : g_exp
         logic [EXC_W-1:0] ex_q, ex_lim;
         always_comb begin
            for (int i = 0; i < EXC_W; i++) ex_lim[i] = (i < int'(exp));
         end
         assign ex_last = (ex_q == ex_lim);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   ex_q <= '0;
            else if (restart || !run)     ex_q <= '0;
            else if (tick && pd_last)     ex_q <= ex_last ? '0 : ex_q + 1'b1;
         end
         // R4: exponent stage never passes its limit
         p_exp_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ex_q <= ex_lim);
      end
   endgenerate

   assign step = run && tick && pd_last && ex_last;

   // R4: pre-divider stays inside its ratio
   p_pd_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q <= div_last(div_idx));

endmodule

// File: rtl/pwmb_pattern.sv
module pwmb_pattern #(
   parameter  int CNT_W = 9,
   localparam int FULL  = 1 << CNT_W
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        run,
   input  logic        step,
   input  logic [15:0] duty,
   input  logic        gate_en,
   input  logic        gate_tri,
   input  logic        gate_pwm,
   output logic        pwm_o,
   output logic        oe_o,
   output logic        boundary
);

   logic [CNT_W-1:0] cnt_q;
   logic             raw;

   assign boundary = step && (&cnt_q);
   assign raw      = ({16'd0, duty} >= 32'(FULL)) || (32'(cnt_q) < {16'd0, duty});
   assign pwm_o    = gate_en && gate_pwm && raw;
   assign oe_o     = gate_en || !gate_tri;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (restart || !run) cnt_q <= '0;
      else if (step)            cnt_q <= cnt_q + 1'b1;
   end

   // R3: a stopped channel holds its step count at zero
   p_stop_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

   // R4: the count wraps to zero after the last step
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !restart) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwmb_pkg::*;
#(
   parameter  int         NUM_CH    = 4,
   parameter  int         CNT_W     = 9,
   parameter  int         TICK_N    = 3,
   parameter  int         MAX_EXP   = 7,
   parameter  logic [7:0] KIND_CODE = KIND_PLAIN,
   localparam int         CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [CH_W+7:0]   bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [TICK_N-1:0] ref_tick,
   output logic [NUM_CH-1:0] pwm_out,
   output logic [NUM_CH-1:0] pwm_oe
);

   generate
      if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_ch
         $error("pwm_bank: NUM_CH out of range");
      end
      if (CNT_W < 2 || CNT_W > 15) begin : g_bad_cnt
         $error("pwm_bank: CNT_W out of range");
      end
      if (TICK_N < 1 || TICK_N > 3) begin : g_bad_tick
         $error("pwm_bank: TICK_N must be 1..3");
      end
      if (MAX_EXP < 0 || MAX_EXP > 7) begin : g_bad_exp
         $error("pwm_bank: MAX_EXP must be 0..7");
      end
   endgenerate

   logic [CH_W-1:0] ch_sel;
   logic [7:0]      ofs;
   logic [7:0]      rd_arr [NUM_CH];

   assign ch_sel = bus_addr[CH_W+7:8];
   assign ofs    = bus_addr[7:0];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pwm_cfg_t act;
      logic     wr, restart, en, tri_sel, src_pwm, step, bnd, tick, run;

      assign wr  = bus_wr && (ch_sel == CH_W'(g));
      assign run = (act.clk_sel != 2'd0);

      always_comb begin
         tick = 1'b0;
         for (int t = 0; t < TICK_N; t++)
            if (act.clk_sel == 2'(t + 1)) tick = ref_tick[t];
      end

      pwmb_chan_regs #(.KIND_CODE(KIND_CODE)) regs_i (
         .clk(clk), .rst_n(rst_n), .wr_en(wr), .ofs(ofs), .wdata(bus_wdata),
         .boundary(bnd), .rdata(rd_arr[g]), .act_cfg(act), .restart(restart),
         .gate_en(en), .gate_tri(tri_sel), .gate_pwm(src_pwm));

      pwmb_prescale #(.MAX_EXP(MAX_EXP)) pre_i (
         .clk(clk), .rst_n(rst_n), .restart(restart), .run(run), .tick(tick),
         .div_idx(act.div_idx), .exp(act.exp), .step(step));

      pwmb_pattern #(.CNT_W(CNT_W)) pat_i (
         .clk(clk), .rst_n(rst_n), .restart(restart), .run(run), .step(step),
         .duty(act.duty), .gate_en(en), .gate_tri(tri_sel), .gate_pwm(src_pwm),
         .pwm_o(pwm_out[g]), .oe_o(pwm_oe[g]), .boundary(bnd));
   end

   always_comb begin
      bus_rdata = 8'h00;
      for (int c = 0; c < NUM_CH; c++)
         if (int'(ch_sel) == c) bus_rdata = rd_arr[c];
   end

   // R9: a channel with its output disabled never shows a high level
   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      p_gate_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !g_ch[g].en |-> !pwm_out[g]);
   end

endmodule

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [9:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] ref_tick = '0;
   logic [3:0] pwm_out, pwm_oe;

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   bit    done = 0;
   string phase = "R1";

   always #2 clk = ~clk;

   pwm_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
      .pwm_out(pwm_out), .pwm_oe(pwm_oe));

   // tick patterns: slow every 7th cycle, medium every 3rd, fast every cycle
   always @(negedge clk) begin
      cyc++;
      ref_tick[0] = (cyc % 7 == 0);
      ref_tick[1] = (cyc % 3 == 0);
      ref_tick[2] = 1'b1;
   end

   // behavioural reference model
   int m_sclk[4], m_sdiv[4], m_sduty[4], m_glitch[4], m_gate[4];
   int m_aclk[4], m_aidx[4], m_aexp[4], m_aduty[4];
   int m_pend[4], m_pd[4], m_ex[4], m_cnt[4];
   int t_ofs, t_plast, t_elast;
   bit t_wr, t_sreq, t_run, t_tk, t_stp, t_bnd, t_ld;

   function automatic int ratio_of(int i);
      case (i)
         0: return 1;
         1: return 3;
         2: return 5;
         default: return 6;
      endcase
   endfunction

   always @(posedge clk) begin
      for (int c = 0; c < 4; c++) begin
         if (!rst_n) begin
            m_sclk[c] = 0; m_sdiv[c] = 0; m_sduty[c] = 0; m_glitch[c] = 0; m_gate[c] = 0;
            m_aclk[c] = 0; m_aidx[c] = 0; m_aexp[c] = 0; m_aduty[c] = 0;
            m_pend[c] = 0; m_pd[c] = 0; m_ex[c] = 0; m_cnt[c] = 0;
         end else begin
            t_ofs   = int'(bus_addr[7:0]);
            t_wr    = bus_wr && (int'(bus_addr[9:8]) == c);
            t_sreq  = t_wr && (t_ofs == 'h47) && bus_wdata[0];
            t_run   = (m_aclk[c] != 0);
            t_tk    = t_run ? ref_tick[m_aclk[c]-1] : 1'b0;
            t_plast = ratio_of(m_aidx[c]) - 1;
            t_elast = (1 << m_aexp[c]) - 1;
            t_stp   = t_tk && (m_pd[c] == t_plast) && (m_ex[c] == t_elast);
            t_bnd   = t_stp && (m_cnt[c] == 511);
            t_ld    = (t_sreq && (m_glitch[c] == 0 || !t_run)) || (m_pend[c] != 0 && t_bnd);
            if (t_ld || !t_run) begin
               m_pd[c] = 0; m_ex[c] = 0; m_cnt[c] = 0;
            end else if (t_tk) begin
               if (m_pd[c] == t_plast) begin
                  m_pd[c] = 0;
                  if (m_ex[c] == t_elast) begin
                     m_ex[c] = 0;
                     m_cnt[c] = (m_cnt[c] + 1) % 512;
                  end else m_ex[c]++;
               end else m_pd[c]++;
            end
            if (t_ld) begin
               m_aclk[c]  = m_sclk[c] & 3;
               m_aexp[c]  = m_sdiv[c] & 7;
               m_aidx[c]  = (m_sdiv[c] >> 5) & 3;
               m_aduty[c] = m_sduty[c];
            end
            m_pend[c] = t_ld ? 0 : (t_sreq ? 1 : m_pend[c]);
            if (t_wr) begin
               case (t_ofs)
                  'h41: m_sclk[c]   = int'(bus_wdata) & 'h07;
                  'h42: m_sdiv[c]   = int'(bus_wdata) & 'h67;
                  'h43: m_glitch[c] = (bus_wdata[5]) ? 1 : 0;
                  'h44: m_sduty[c]  = (m_sduty[c] & 'hFF00) | int'(bus_wdata);
                  'h45: m_sduty[c]  = (m_sduty[c] & 'h00FF) | (int'(bus_wdata) << 8);
                  'h46: m_gate[c]   = int'(bus_wdata) & 'hA6;
                  default: ;
               endcase
            end
         end
      end
   end

   function automatic int exp_rd(int c, int o);
      case (o)
         'h05: return 'h0B;
         'h41: return m_sclk[c];
         'h42: return m_sdiv[c];
         'h43: return m_glitch[c] << 5;
         'h44: return m_sduty[c] & 'hFF;
         'h45: return (m_sduty[c] >> 8) & 'hFF;
         'h46: return m_gate[c];
         default: return 0;
      endcase
   endfunction

   // compare every cycle, one ns after the falling edge
   always @(negedge clk) begin
      #1;
      if (!done) begin
         for (int c = 0; c < 4; c++) begin
            bit en, tr, sp, raw, e_out, e_oe;
            en    = m_gate[c][7];
            tr    = m_gate[c][5];
            sp    = m_gate[c][2];
            raw   = (m_aduty[c] >= 512) || (m_cnt[c] < m_aduty[c]);
            e_out = en && sp && raw;
            e_oe  = en || !tr;
            n_cmp++;
            if (pwm_out[c] !== e_out || pwm_oe[c] !== e_oe) begin
               n_bad++;
               $display("FAIL [%s] ch%0d out/oe actual=%b/%b expected=%b/%b at cycle %0d",
                        phase, c, pwm_out[c], pwm_oe[c], e_out, e_oe, cyc);
            end
         end
         n_cmp++;
         if (int'(bus_rdata) != exp_rd(int'(bus_addr[9:8]), int'(bus_addr[7:0]))) begin
            n_bad++;
            $display("FAIL [%s] rdata @%h actual=%h expected=%h", phase, bus_addr,
                     bus_rdata, exp_rd(int'(bus_addr[9:8]), int'(bus_addr[7:0])));
         end
      end
   end

   task automatic wr_reg(int ch, int o, int v);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 10'((ch << 8) | o); bus_wdata = 8'(v);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(int ch, int o);
      @(negedge clk);
      bus_addr = 10'((ch << 8) | o);
      @(negedge clk);
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL [watchdog] run did not complete, actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      // R1: reset values and kind code
      phase = "R1";
      wait_cyc(5);
      rst_n = 1'b1;
      for (int c = 0; c < 4; c++) rd_reg(c, 'h05);
      for (int o = 'h40; o <= 'h47; o++) rd_reg(2, o);

      // R2: register map, masks and ignored offsets
      phase = "R2";
      wr_reg(1, 'h41, 'hFF); wr_reg(1, 'h42, 'hFF); wr_reg(1, 'h43, 'hFF);
      wr_reg(1, 'h44, 'hA5); wr_reg(1, 'h45, 'h3C); wr_reg(1, 'h46, 'hFF);
      wr_reg(1, 'h10, 'hFF); wr_reg(1, 'h05, 'h55);
      for (int o = 'h40; o <= 'h48; o++) rd_reg(1, o);
      rd_reg(1, 'h10); rd_reg(1, 'h05);
      wr_reg(1, 'h41, 0); wr_reg(1, 'h42, 0); wr_reg(1, 'h43, 0);
      wr_reg(1, 'h44, 0); wr_reg(1, 'h45, 0); wr_reg(1, 'h46, 0);

      // R3/R5: fast tick, ratio 1, no exponent, duty 100
      phase = "R3";
      wr_reg(0, 'h41, 'h07); wr_reg(0, 'h42, 0);
      wr_reg(0, 'h44, 100); wr_reg(0, 'h45, 0);
      wr_reg(0, 'h46, 'h84); wr_reg(0, 'h47, 1);
      wait_cyc(1100);

      // R4: medium tick, ratio 3, exponent 1, duty 5
      phase = "R4";
      wr_reg(1, 'h41, 'h06); wr_reg(1, 'h42, 'h21);
      wr_reg(1, 'h44, 5); wr_reg(1, 'h46, 'h84); wr_reg(1, 'h47, 1);
      wait_cyc(2500);

      // R5: duty extremes
      phase = "R5";
      wr_reg(0, 'h44, 0);    wr_reg(0, 'h45, 0); wr_reg(0, 'h47, 1); wait_cyc(600);
      wr_reg(0, 'h44, 'h58); wr_reg(0, 'h45, 2); wr_reg(0, 'h47, 1); wait_cyc(600);
      wr_reg(0, 'h44, 0);    wr_reg(0, 'h45, 2); wr_reg(0, 'h47, 1); wait_cyc(600);
      wr_reg(0, 'h44, 'hFF); wr_reg(0, 'h45, 1); wr_reg(0, 'h47, 1); wait_cyc(600);

      // R6: shadow writes and a sync write with bit 0 clear do nothing
      phase = "R6";
      wr_reg(0, 'h44, 200); wr_reg(0, 'h45, 0); wr_reg(0, 'h41, 'h06);
      wait_cyc(400);
      wr_reg(0, 'h47, 'h02);
      wait_cyc(400);
      wr_reg(0, 'h41, 'h07);

      // R7: immediate sync mid-period restarts the count
      phase = "R7";
      wait_cyc(250);
      wr_reg(0, 'h47, 1);
      wait_cyc(300);

      // R8: glitch-free sync waits for the wrap; stopped channel applies at once
      phase = "R8";
      wr_reg(0, 'h43, 'h20); wr_reg(0, 'h44, 50); wr_reg(0, 'h47, 1);
      wait_cyc(1100);
      wr_reg(3, 'h43, 'h20); wr_reg(3, 'h41, 'h03); wr_reg(3, 'h44, 10);
      wr_reg(3, 'h46, 'h84); wr_reg(3, 'h47, 1);
      wait_cyc(200);

      // R9: gate register combinations
      phase = "R9";
      wr_reg(2, 'h41, 'h03); wr_reg(2, 'h44, 0); wr_reg(2, 'h45, 1); wr_reg(2, 'h47, 1);
      wr_reg(2, 'h46, 'h20); wait_cyc(50);
      wr_reg(2, 'h46, 'h00); wait_cyc(50);
      wr_reg(2, 'h46, 'h80); wait_cyc(50);
      wr_reg(2, 'h46, 'hA4); wait_cyc(600);
      wr_reg(2, 'h46, 'h24); wait_cyc(50);

      // R10: duty written, enable set, duty rewritten, then sync
      phase = "R10";
      wr_reg(3, 'h43, 0); wr_reg(3, 'h46, 0); wr_reg(3, 'h41, 'h01);
      wr_reg(3, 'h44, 40); wr_reg(3, 'h45, 0);
      wr_reg(3, 'h46, 'h84);
      wr_reg(3, 'h44, 40); wr_reg(3, 'h45, 0);
      wr_reg(3, 'h47, 1);
      wait_cyc(1100);

      // R3: slow tick select, then stop with code 0
      phase = "R3";
      wr_reg(1, 'h41, 'h01); wr_reg(1, 'h47, 1); wait_cyc(400);
      wr_reg(1, 'h41, 'h00); wr_reg(1, 'h47, 1); wait_cyc(200);

      // R11: all channels running while one is reprogrammed
      phase = "R11";
      wr_reg(2, 'h46, 'h84); wr_reg(1, 'h41, 'h02); wr_reg(1, 'h47, 1);
      wait_cyc(1000);
      wr_reg(1, 'h44, 'hC8); wr_reg(1, 'h42, 'h40); wr_reg(1, 'h47, 1);
      for (int c = 0; c < 4; c++) rd_reg(c, 'h44);
      wait_cyc(1000);

      finish_run();
   end

endmodule